// File: doc/BRIEF.md
# Flash Command/Status Host Interface

This block is the host-facing command engine of an on-chip flash controller. A byte-wide host writes command codes and reads back either array data or a status byte. The block decodes each code, runs the two-cycle setup that program and erase need, checks the target page against a protected page window, and drives the strobes of a simple flash array for a fixed number of cycles. Every error class is reported through its own sticky status bit.

After reset the host read path shows array data. The first command switches it to the status byte, and it stays there. Program takes the command code followed by one write cycle that carries the address and the data byte. Erase takes the command code followed by one write cycle whose address names the page. The protected window is the inclusive range between two page numbers given on input pins.

Top module: `flash_cmd_host`

## Requirements
- R1: The status byte has BUSY in bit 7, command error in bit 6, protect error in bit 5, setup error in bit 4 and INFO in bit 3 (1 = info block selected). Bits 2..0 read as 0.
- R2: After reset INFO and all error bits are 0, the array is in standby, and host reads return `array_rdata` until the first command write. From that write on, host reads return the status byte.
- R3: Code 8'h01 selects the main block and clears INFO. Code 8'h02 selects the info block and sets INFO. `arr_info_sel` follows INFO, the array stays in standby, and the engine stays idle.
- R4: Code 8'h10 followed by a write to an unprotected address raises BUSY and `arr_prog` for exactly PROG_CYCLES cycles (default 8). During that window `arr_addr` and `arr_wdata` hold the address and data of the second write.
- R5: Code 8'h20 followed by a write to an unprotected address raises BUSY and `arr_erase` for exactly ERASE_CYCLES cycles (default 32). During that window `arr_addr` holds the page base, which is the address with its low PAGE_W bits cleared.
- R6: A host write while BUSY is set is discarded: INFO is unchanged, the command error bit is set, and the running operation completes with its full strobe length.
- R7: A write of any code other than 8'h01, 8'h02, 8'h10, 8'h20, 8'h50 or 8'h70 while idle sets the command error bit and leaves the engine idle.
- R8: If the page number (address bits above PAGE_W) of the second write lies between `prot_lo_page` and `prot_hi_page` inclusive, the protect error bit is set, the engine returns to idle and no strobe is raised.
- R9: A host read in place of the second write of a program or erase aborts the command. The setup error bit is set and no strobe is raised.
- R10: Error bits are sticky. Code 8'h50 clears all three error bits and keeps INFO. Code 8'h70 changes no bit.
- R11: `arr_prog` and `arr_erase` are never high together, and `arr_standby` is high exactly when neither strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write cycle strobe |
| host_rd | input | 1 | Host read cycle strobe |
| host_addr | input | ADDR_W | Host byte address, used on the second write of program and erase |
| host_wdata | input | 8 | Command code or program data |
| host_rdata | output | 8 | Status byte or array data |
| prot_lo_page | input | ADDR_W-PAGE_W | Lowest protected page |
| prot_hi_page | input | ADDR_W-PAGE_W | Highest protected page |
| array_rdata | input | 8 | Read data from the flash array |
| arr_standby | output | 1 | Array standby |
| arr_prog | output | 1 | Program strobe |
| arr_erase | output | 1 | Page erase strobe |
| arr_info_sel | output | 1 | Block select: 1 = info block |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | 8 | Array program data |

## Verification
The assertions assume that the host never raises `host_wr` and `host_rd` in the same cycle. They also assume that the protected window bounds stay constant while a command is in flight. The stimulus sets the window once before reset is released and drives each host cycle as a single-cycle pulse of one strobe only. The strobe-length checks count array cycles with counters in the checker, so they do not depend on how long BUSY is seen from the host side.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_PROG,
        ST_SET_ERASE,
        ST_RUN_PROG,
        ST_RUN_ERASE
    } state_e;

    typedef enum logic [2:0] {
        CK_MAIN,
        CK_INFO,
        CK_PROG,
        CK_ERASE,
        CK_STATUS,
        CK_CLEAR,
        CK_BAD
    } cmd_kind_e;

    localparam logic [7:0] OP_MAIN   = 8'h01;
    localparam logic [7:0] OP_INFO   = 8'h02;
    localparam logic [7:0] OP_PROG   = 8'h10;
    localparam logic [7:0] OP_ERASE  = 8'h20;
    localparam logic [7:0] OP_CLEAR  = 8'h50;
    localparam logic [7:0] OP_STATUS = 8'h70;

    typedef struct packed {
        logic cmd_err;
        logic prot_err;
        logic setup_err;
        logic info;
    } flags_t;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_kind_e  kind
);
    always_comb begin
        case (code)
            OP_MAIN:   kind = CK_MAIN;
            OP_INFO:   kind = CK_INFO;
            OP_PROG:   kind = CK_PROG;
            OP_ERASE:  kind = CK_ERASE;
            OP_STATUS: kind = CK_STATUS;
            OP_CLEAR:  kind = CK_CLEAR;
            default:   kind = CK_BAD;
        endcase
    end
endmodule

// File: rtl/flash_prot_check.sv
module flash_prot_check #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 6,
    localparam int PN_W  = ADDR_W - PAGE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PN_W-1:0]   lo_page,
    input  logic [PN_W-1:0]   hi_page,
    output logic              hit
);
    logic [PN_W-1:0] page;

    always_comb begin
        page = addr[ADDR_W-1:PAGE_W];
        hit  = (page >= lo_page) && (page <= hi_page);
    end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = len;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        last = (cnt_q == CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flash_cmd_host.sv
module flash_cmd_host
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int PAGE_W       = 6,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 32,
    localparam int PN_W        = ADDR_W - PAGE_W,
    localparam int MAX_CYC     = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
    localparam int CNT_W       = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [PN_W-1:0]   prot_lo_page,
    input  logic [PN_W-1:0]   prot_hi_page,
    input  logic [7:0]        array_rdata,
    output logic              arr_standby,
    output logic              arr_prog,
    output logic              arr_erase,
    output logic              arr_info_sel,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata
);

    typedef struct packed {
        state_e            state;
        flags_t            flags;
        logic              show_status;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    state_e           state_q;
    cmd_kind_e        kind;
    logic             prot_hit;
    logic             tmr_start;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_last;
    logic             busy;
    logic [7:0]       status_w;

    flash_cmd_decode u_dec (
        .code (host_wdata),
        .kind (kind)
    );

    flash_prot_check #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_prot (
        .addr    (host_addr),
        .lo_page (prot_lo_page),
        .hi_page (prot_hi_page),
        .hit     (prot_hit)
    );

    flash_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        tmr_len   = '0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (host_wr) begin
                    ctl_d.show_status = 1'b1;
                    case (kind)
                        CK_MAIN:  ctl_d.flags.info  = 1'b0;
                        CK_INFO:  ctl_d.flags.info  = 1'b1;
                        CK_PROG:  ctl_d.state       = ST_SET_PROG;
                        CK_ERASE: ctl_d.state       = ST_SET_ERASE;
                        CK_CLEAR: begin
                            ctl_d.flags.cmd_err   = 1'b0;
                            ctl_d.flags.prot_err  = 1'b0;
                            ctl_d.flags.setup_err = 1'b0;
                        end
                        CK_STATUS: ctl_d.show_status = 1'b1;
                        default:  ctl_d.flags.cmd_err = 1'b1;
                    endcase
                end
            end
            ST_SET_PROG, ST_SET_ERASE: begin
                if (host_rd) begin
                    ctl_d.flags.setup_err = 1'b1;
                    ctl_d.state           = ST_IDLE;
                end else if (host_wr) begin
                    if (prot_hit) begin
                        ctl_d.flags.prot_err = 1'b1;
                        ctl_d.state          = ST_IDLE;
                    end else begin
                        tmr_start = 1'b1;
                        if (ctl_q.state == ST_SET_PROG) begin
                            ctl_d.addr  = host_addr;
                            ctl_d.wdata = host_wdata;
                            tmr_len     = CNT_W'(PROG_CYCLES);
                            ctl_d.state = ST_RUN_PROG;
                        end else begin
                            ctl_d.addr  = {host_addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
                            tmr_len     = CNT_W'(ERASE_CYCLES);
                            ctl_d.state = ST_RUN_ERASE;
                        end
                    end
                end
            end
            ST_RUN_PROG, ST_RUN_ERASE: begin
                if (host_wr) ctl_d.flags.cmd_err = 1'b1;
                if (tmr_last) ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, flags: '0, show_status: 1'b0,
                       addr: '0, wdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        state_q      = ctl_q.state;
        busy         = (ctl_q.state == ST_RUN_PROG) || (ctl_q.state == ST_RUN_ERASE);
        status_w     = {busy, ctl_q.flags.cmd_err, ctl_q.flags.prot_err,
                        ctl_q.flags.setup_err, ctl_q.flags.info, 3'b000};
        host_rdata   = ctl_q.show_status ? status_w : array_rdata;
        arr_prog     = (ctl_q.state == ST_RUN_PROG);
        arr_erase    = (ctl_q.state == ST_RUN_ERASE);
        arr_standby  = !busy;
        arr_info_sel = ctl_q.flags.info;
        arr_addr     = ctl_q.addr;
        arr_wdata    = ctl_q.wdata;
    end

endmodule

// File: rtl/flash_cmd_host_chk.sv
module flash_cmd_host_chk
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_wdata,
    input state_e     state_q,
    input logic [7:0] status_w,
    input logic       arr_standby,
    input logic       arr_prog,
    input logic       arr_erase
);
    logic [15:0] prog_run, erase_run;
    logic        in_run, in_setup, in_idle;

    always_comb begin
        in_run   = (state_q == ST_RUN_PROG) || (state_q == ST_RUN_ERASE);
        in_setup = (state_q == ST_SET_PROG) || (state_q == ST_SET_ERASE);
        in_idle  = (state_q == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_run  <= '0;
            erase_run <= '0;
        end else begin
            prog_run  <= arr_prog  ? prog_run + 16'd1  : 16'd0;
            erase_run <= arr_erase ? erase_run + 16'd1 : 16'd0;
        end
    end

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_prog && arr_erase) && (arr_standby == !(arr_prog || arr_erase)));

    assert_prog_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_prog) |-> (prog_run == 16'(PROG_CYCLES)));

    assert_erase_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_erase) |-> (erase_run == 16'(ERASE_CYCLES)));

    assert_busy_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && host_wr) |=> (status_w[6] && $stable(status_w[3])));

    assert_setup_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_setup && host_rd) |=> (status_w[4] && !arr_prog && !arr_erase));

    assert_prot_nostrobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_w[5]) |-> (!arr_prog && !arr_erase));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && host_wr && host_wdata == OP_CLEAR) |=> (status_w[6:4] == 3'b000));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w[5] && !(in_idle && host_wr && host_wdata == OP_CLEAR)) |=> status_w[5]);

endmodule

bind flash_cmd_host flash_cmd_host_chk #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .state_q     (state_q),
    .status_w    (status_w),
    .arr_standby (arr_standby),
    .arr_prog    (arr_prog),
    .arr_erase   (arr_erase)
);

// File: tb/sim_flash_cmd_host.sv
module sim_flash_cmd_host;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int PAGE_W = 6;
    localparam int PN_W   = ADDR_W - PAGE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [7:0]        host_wdata = '0;
    logic [7:0]        host_rdata;
    logic [PN_W-1:0]   prot_lo_page = 6'd4;
    logic [PN_W-1:0]   prot_hi_page = 6'd7;
    logic [7:0]        array_rdata = 8'h3C;
    logic              arr_standby, arr_prog, arr_erase, arr_info_sel;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_host u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .prot_lo_page(prot_lo_page), .prot_hi_page(prot_hi_page),
        .array_rdata(array_rdata), .arr_standby(arr_standby), .arr_prog(arr_prog),
        .arr_erase(arr_erase), .arr_info_sel(arr_info_sel), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata)
    );

    // op: 0 = write, 1 = read, 2 = wait for BUSY to drop
    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] a;
        logic [7:0]  d;
        logic [7:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 12'h000, 8'h01, 8'h00, 4'd3},  // R3 main
        '{2'd0, 12'h000, 8'h02, 8'h08, 4'd3},  // R3 info
        '{2'd0, 12'h000, 8'h3F, 8'h48, 4'd7},  // R7 reserved
        '{2'd0, 12'h000, 8'h50, 8'h08, 4'd10}, // R10 clear keeps INFO
        '{2'd0, 12'h000, 8'h10, 8'h08, 4'd4},  // R4 setup
        '{2'd0, 12'h100, 8'hAA, 8'h28, 4'd8},  // R8 low bound
        '{2'd0, 12'h000, 8'h70, 8'h28, 4'd10}, // R10 status no change
        '{2'd0, 12'h000, 8'h50, 8'h08, 4'd10},
        '{2'd0, 12'h000, 8'h20, 8'h08, 4'd5},
        '{2'd0, 12'h1FF, 8'h00, 8'h28, 4'd8},  // R8 high bound
        '{2'd0, 12'h000, 8'h50, 8'h08, 4'd10},
        '{2'd0, 12'h000, 8'h20, 8'h08, 4'd5},
        '{2'd1, 12'h000, 8'h00, 8'h18, 4'd9},  // R9 erase abort
        '{2'd0, 12'h000, 8'h01, 8'h10, 4'd3},  // R3 main, R10 sticky
        '{2'd0, 12'h000, 8'h50, 8'h00, 4'd10},
        '{2'd0, 12'h000, 8'h10, 8'h00, 4'd4},
        '{2'd1, 12'h000, 8'h00, 8'h10, 4'd9},  // R9 program abort
        '{2'd0, 12'h000, 8'h50, 8'h00, 4'd10},
        '{2'd0, 12'h000, 8'h10, 8'h00, 4'd4},
        '{2'd0, 12'h0FF, 8'h5A, 8'h80, 4'd4},  // R4 page 3 free
        '{2'd0, 12'h000, 8'h02, 8'hC0, 4'd6},  // R6 rejected
        '{2'd2, 12'h000, 8'h00, 8'h40, 4'd6},  // R6 completes
        '{2'd0, 12'h000, 8'h50, 8'h00, 4'd10},
        '{2'd0, 12'h000, 8'h20, 8'h00, 4'd5},
        '{2'd0, 12'h200, 8'h00, 8'h80, 4'd5},  // R5 page 8 free
        '{2'd2, 12'h000, 8'h00, 8'h00, 4'd5},
        '{2'd0, 12'h000, 8'h02, 8'h08, 4'd3},
        '{2'd0, 12'h000, 8'h70, 8'h08, 4'd10},
        '{2'd0, 12'h000, 8'h50, 8'h08, 4'd1}   // R1 layout
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && host_rdata[7]; i++) @(negedge clk);
    endtask

    task automatic count_strobe(input bit erase, input int limit, output int n, output int bad_sb);
        n = 0; bad_sb = 0;
        for (int i = 0; i < limit; i++) begin
            if (erase ? arr_erase : arr_prog) begin
                n++;
                if (arr_standby) bad_sb++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n, sb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset read path", 16'(host_rdata), 16'h003C);
        check("R2 reset standby", 16'(arr_standby), 16'h0001);
        check("R2 reset info", 16'(arr_info_sel), 16'h0000);
        wr(12'h000, 8'h70);
        check("R2 status after first command", 16'(host_rdata), 16'h0000);

        for (int v = 0; v < NV; v++) begin
            case (VEC[v].op)
                2'd0: wr(VEC[v].a, VEC[v].d);
                2'd1: rd();
                default: wait_idle();
            endcase
            n_chk++;
            if (host_rdata !== VEC[v].exp) begin
                n_fail++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h",
                         VEC[v].req, v, host_rdata, VEC[v].exp);
            end
        end
        check("R3 info select pin", 16'(arr_info_sel), 16'h0001);

        // R4 program strobe length and latched address/data
        wr(12'h000, 8'h10);
        wr(12'h2C3, 8'h96);
        check("R4 program addr", 16'(arr_addr), 16'h02C3);
        check("R4 program data", 16'(arr_wdata), 16'h0096);
        count_strobe(1'b0, 40, n, sb);
        check("R4 program length", 16'(n), 16'd8);
        check("R11 standby low while programming", 16'(sb), 16'd0);

        // R5 erase strobe length and page base
        wr(12'h000, 8'h20);
        wr(12'h8E7, 8'h00);
        check("R5 erase page base", 16'(arr_addr), 16'h08C0);
        count_strobe(1'b1, 60, n, sb);
        check("R5 erase length", 16'(n), 16'd32);
        check("R11 standby low while erasing", 16'(sb), 16'd0);
        check("R11 standby after erase", 16'(arr_standby), 16'h0001);

        // R8 protected program raises no strobe
        wr(12'h000, 8'h10);
        wr(12'h180, 8'h01);
        count_strobe(1'b0, 12, n, sb);
        check("R8 no program strobe", 16'(n), 16'd0);
        check("R8 protect bit", 16'(host_rdata[5]), 16'h0001);

        // R9 aborted erase raises no strobe
        wr(12'h000, 8'h50);
        wr(12'h000, 8'h20);
        rd();
        count_strobe(1'b1, 40, n, sb);
        check("R9 no erase strobe", 16'(n), 16'd0);
        check("R9 setup bit", 16'(host_rdata[4]), 16'h0001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule